// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block behaves like a small byte-wide serial EEPROM attached to a two-wire bus. It runs on a fast system clock and oversamples the bus clock and data lines. It pulls the data line low through an open-drain enable. A register array stands in for the nonvolatile cells. The block decodes the device select byte and then handles single-byte and page writes, reads from the internal address counter, random reads and sequential reads.

Written bytes go into a one-page buffer. They are copied into the array only after the host closes the transfer with STOP. During that copy the block runs a write window of fixed length, counted in system clocks. While the window is open the block stays silent, so the host can poll for the end of the write with START plus a select byte. A protect input can shield the upper half of the array, or the whole array in the larger configurations. Bytes aimed at shielded locations are still acknowledged, but they are discarded when the page is copied.

Top module: `ee2w_slave`

## Requirements
- R1: SDA is sampled on each rising SCL edge, and the block changes its SDA drive only while SCL is low. A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP. Either one ends the byte in progress.
- R2: Bytes travel most significant bit first, eight bits each. The block acknowledges each byte it accepts by pulling SDA low for the whole ninth clock, and it releases SDA again after that clock.
- R3: The select byte is the pattern 1010 in bits 7..4, a 3-bit field in bits 3..1, and a direction bit in bit 0 (1 = read, 0 = write). With the default 256-byte array the whole field must equal strap_i. When the array is larger, the low bits of the field supply the upper word-address bits and only the remaining upper bits are compared. On a mismatch the block does not acknowledge and ignores the bus until the next START.
- R4: In a write, the byte after the select byte sets the word address. The data byte that follows is acknowledged and lands at that address.
- R5: During a write, only the address bits inside a page (3 bits for the default 8-byte page) count up. Extra bytes wrap to the start of the same page and replace the earlier ones. Buffered bytes are copied to the array only on STOP. A START that arrives before the STOP discards them.
- R6: A STOP that ends a write carrying data opens a write window of WR_CYCLES clocks. During this window the block ignores the bus and does not acknowledge its select byte. After the window it answers normally. A STOP with no data opens no window.
- R7: An address counter holds the last accessed address plus one. After a write it wraps within the page. A read that starts straight after the select byte returns the byte at the counter.
- R8: A random read is a write of the select byte and word address with no data, then a repeated START and a read select byte. It returns the byte at the word address.
- R9: A sequential read returns successive bytes while the host acknowledges. The address wraps from the last byte of the array to byte 0. A host non-acknowledge ends the read, and the block leaves SDA released.
- R10: With wp_i high when the write's STOP arrives, bytes for protected locations are acknowledged but not stored. The protected locations are the upper half (address bit 7 set for 256 bytes) in arrays under 1024 bytes, and the whole array otherwise. Unprotected bytes are stored. With wp_i low, every byte is stored.
- R11: After reset SDA is released, the array holds zeros and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 3 | Board-level select straps |
| wp_i | input | 1 | Write protect level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench plays the host and keeps a shadow array with its own copy of the address counter. Writes come in three forms: a single byte, a short page in the middle of a page, and a page that runs past its boundary. Together they separate correct page wrap from an address that counts across the whole array or does not count at all. Reads come as random reads, current-address reads after both writes and reads, and a sequential read across the top of the array. These show whether the counter follows the write rule or the read rule. Further cases cover a select byte with wrong straps, a write cut short by a repeated START, polling during and after the write window, and writes with protect high to both halves of the array. These show whether data is kept, dropped or protected by level.

// File: rtl/ee2w_pkg.sv
`timescale 1ns/1ps
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } link_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee2w_bus_sense.sv
`timescale 1ns/1ps
module ee2w_bus_sense #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_sh_q, sda_sh_q;
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sh_q <= {scl_sh_q[SYNC_N-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[SYNC_N-2:0], sda_i};
      scl_d_q  <= scl_sh_q[SYNC_N-1];
      sda_d_q  <= sda_sh_q[SYNC_N-1];
    end
  end

  assign scl_lvl_o  = scl_sh_q[SYNC_N-1];
  assign sda_lvl_o  = sda_sh_q[SYNC_N-1];
  assign scl_rise_o = !scl_d_q && scl_lvl_o;
  assign scl_fall_o = scl_d_q && !scl_lvl_o;
  // data edges only count as framing while clock stays high
  assign start_o    = scl_d_q && scl_lvl_o && sda_d_q && !sda_lvl_o;
  assign stop_o     = scl_d_q && scl_lvl_o && !sda_d_q && sda_lvl_o;
endmodule

// File: rtl/ee2w_page_store.sv
`timescale 1ns/1ps
module ee2w_page_store #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 400,
  parameter bit WP_ALL    = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wp_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_slot_i,
  input  logic [7:0]               buf_data_i,
  input  logic [ADDR_W-PAGE_W-1:0] row_i,
  input  logic                     buf_clr_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int ROW_W  = ADDR_W - PAGE_W;
  localparam int TW     = $clog2(WR_CYCLES + 1);

  logic [7:0]        mem_q  [DEPTH];
  logic [7:0]        pbuf_q [PAGE_N];
  logic [PAGE_N-1:0] pval_q;
  logic [ROW_W-1:0]  row_q;
  logic              busy_q, wp_lat_q;
  logic [TW-1:0]     tmr_q;

  logic [PAGE_W-1:0] cm_slot;
  logic [ADDR_W-1:0] cm_addr;
  logic              cm_zone, cm_we;

  assign cm_slot = tmr_q[PAGE_W-1:0];
  assign cm_addr = {row_q, cm_slot};

  generate
    if (WP_ALL) begin : g_wp_all
      assign cm_zone = 1'b1;
    end else begin : g_wp_upper
      assign cm_zone = cm_addr[ADDR_W-1];
    end
  endgenerate

  // one page slot per clock during the start of the write window
  assign cm_we = busy_q && (tmr_q < TW'(PAGE_N)) && pval_q[cm_slot] && !(wp_lat_q && cm_zone);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (cm_we) begin
      mem_q[cm_addr] <= pbuf_q[cm_slot];
    end
  end

  always_ff @(posedge clk_i) begin
    if (buf_we_i) pbuf_q[buf_slot_i] <= buf_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pval_q   <= '0;
      row_q    <= '0;
      busy_q   <= 1'b0;
      wp_lat_q <= 1'b0;
      tmr_q    <= '0;
    end else if (busy_q) begin
      tmr_q <= tmr_q + TW'(1);
      if (tmr_q == TW'(WR_CYCLES - 1)) begin
        busy_q <= 1'b0;
        pval_q <= '0;
      end
    end else if (commit_i) begin
      if (|pval_q) begin
        busy_q   <= 1'b1;
        tmr_q    <= '0;
        wp_lat_q <= wp_i;
      end
    end else if (buf_clr_i) begin
      pval_q <= '0;
    end else if (buf_we_i) begin
      pval_q[buf_slot_i] <= 1'b1;
      row_q              <= row_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;

  assert_buf_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> !busy_q);
  assert_row_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(row_q));
  assert_window_from_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(commit_i));
endmodule

// File: rtl/ee2w_link_fsm.sv
`timescale 1ns/1ps
module ee2w_link_fsm
  import ee2w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_lvl_i,
  input  logic                     sda_lvl_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic [2:0]               strap_i,
  input  logic                     busy_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_slot_o,
  output logic [7:0]               buf_data_o,
  output logic [ADDR_W-PAGE_W-1:0] row_o,
  output logic                     buf_clr_o,
  output logic                     commit_o,
  output logic                     sda_oe_o
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [2:0] STRAP_MASK = 3'(3'b111 << HI_W);

  link_st_e          st_q;
  logic [3:0]        cnt_q;
  logic [7:0]        rx_q, tx_q;
  logic [ADDR_W-1:0] ctr_q;
  logic [2:0]        pg_q;
  logic              rd_q, nak_q, oe_q;
  logic              we_q, clr_q, commit_q;
  logic [PAGE_W-1:0] slot_q;
  logic [7:0]        data_q;

  logic              active, dev_hit;
  logic [ADDR_W-1:0] waddr_full, page_inc;

  assign active     = st_q inside {ST_DEV, ST_WADDR, ST_WDATA, ST_RDATA};
  assign dev_hit    = (rx_q[7:4] == DEV_TYPE) && (((rx_q[3:1] ^ strap_i) & STRAP_MASK) == 3'b000);
  assign waddr_full = ADDR_W'({pg_q, rx_q});
  assign page_inc   = {ctr_q[ADDR_W-1:PAGE_W], ctr_q[PAGE_W-1:0] + PAGE_W'(1)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ctr_q    <= '0;
      pg_q     <= '0;
      rd_q     <= 1'b0;
      nak_q    <= 1'b1;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      clr_q    <= 1'b0;
      commit_q <= 1'b0;
      slot_q   <= '0;
      data_q   <= '0;
    end else begin
      we_q     <= 1'b0;
      clr_q    <= 1'b0;
      commit_q <= 1'b0;
      if (busy_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_i) begin
        st_q  <= ST_DEV;
        cnt_q <= '0;
        oe_q  <= 1'b0;
        clr_q <= 1'b1;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        oe_q     <= 1'b0;
        commit_q <= 1'b1;
      end else if (active && scl_rise_i) begin
        if (cnt_q < 4'd8) rx_q <= {rx_q[6:0], sda_lvl_i};
        else              nak_q <= sda_lvl_i;
        cnt_q <= cnt_q + 4'd1;
      end else if (active && scl_fall_i) begin
        if (cnt_q == 4'd8) begin
          case (st_q)
            ST_DEV: begin
              if (dev_hit) begin
                oe_q <= 1'b1;
                rd_q <= rx_q[0];
                pg_q <= rx_q[3:1];
              end else begin
                st_q <= ST_HOLD;
                oe_q <= 1'b0;
              end
            end
            ST_WADDR: begin
              oe_q  <= 1'b1;
              ctr_q <= waddr_full;
            end
            ST_WDATA: begin
              oe_q   <= 1'b1;
              we_q   <= 1'b1;
              slot_q <= ctr_q[PAGE_W-1:0];
              data_q <= rx_q;
              ctr_q  <= page_inc;
            end
            default: oe_q <= 1'b0;  // host owns the ack slot of a read byte
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_q <= '0;
          case (st_q)
            ST_DEV: begin
              if (rd_q) begin
                tx_q  <= rd_data_i;
                oe_q  <= !rd_data_i[7];
                ctr_q <= ctr_q + ADDR_W'(1);
                st_q  <= ST_RDATA;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WADDR;
              end
            end
            ST_WADDR: begin
              oe_q <= 1'b0;
              st_q <= ST_WDATA;
            end
            ST_RDATA: begin
              if (nak_q) begin
                oe_q <= 1'b0;
                st_q <= ST_HOLD;
              end else begin
                tx_q  <= rd_data_i;
                oe_q  <= !rd_data_i[7];
                ctr_q <= ctr_q + ADDR_W'(1);
              end
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (st_q == ST_RDATA && cnt_q != 4'd0) begin
          tx_q <= {tx_q[6:0], 1'b0};
          oe_q <= !tx_q[6];
        end
      end
    end
  end

  assign rd_addr_o  = ctr_q;
  assign buf_we_o   = we_q;
  assign buf_slot_o = slot_q;
  assign buf_data_o = data_q;
  assign row_o      = ctr_q[ADDR_W-1:PAGE_W];
  assign buf_clr_o  = clr_q;
  assign commit_o   = commit_q;
  assign sda_oe_o   = oe_q;

  assert_drive_scl_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_lvl_i);
  assert_ack_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && st_q inside {ST_DEV, ST_WADDR, ST_WDATA}) |-> cnt_q >= 4'd8);
  assert_hold_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HOLD |-> !oe_q);
  assert_busy_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !oe_q);
endmodule

// File: rtl/ee2w_slave.sv
`timescale 1ns/1ps
module ee2w_slave #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 400,
  parameter int SYNC_N     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam bit WP_ALL = (MEM_BYTES >= 1024);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, buf_we, buf_clr, commit;
  logic [PAGE_W-1:0]        buf_slot;
  logic [7:0]               buf_data, rd_data;
  logic [ADDR_W-PAGE_W-1:0] row;
  logic [ADDR_W-1:0]        rd_addr;

  ee2w_bus_sense #(.SYNC_N(SYNC_N)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  ee2w_link_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_link (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev),
    .strap_i, .busy_i(busy), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .buf_we_o(buf_we), .buf_slot_o(buf_slot),
    .buf_data_o(buf_data), .row_o(row), .buf_clr_o(buf_clr),
    .commit_o(commit), .sda_oe_o
  );

  ee2w_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES), .WP_ALL(WP_ALL)) u_store (
    .clk_i, .rst_ni, .wp_i,
    .buf_we_i(buf_we), .buf_slot_i(buf_slot), .buf_data_i(buf_data),
    .row_i(row), .buf_clr_i(buf_clr), .commit_i(commit),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy)
  );
endmodule

// File: tb/sim_ee2w_slave.sv
`timescale 1ns/1ps
module sim_ee2w_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam logic [2:0] STRAPS = 3'b101;
  localparam logic [7:0] DEV_W  = {4'b1010, STRAPS, 1'b0};
  localparam logic [7:0] DEV_R  = {4'b1010, STRAPS, 1'b1};

  typedef struct {
    logic [7:0] v;
    string      tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = host_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  item_t exp_q[$];
  logic [7:0] act_q[$];
  logic [7:0] model [256];
  logic [7:0] wbuf [16];
  logic [7:0] bctr = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  ee2w_slave #(.MEM_BYTES(256), .PAGE_BYTES(8), .WR_CYCLES(400), .SYNC_N(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAPS), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  // monitor: pops observed items and compares them with the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a;
        item_t e;
        a = act_q.pop_front();
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected item actual=%h expected=none", a);
        end else begin
          e = exp_q.pop_front();
          if (a !== e.v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", e.tag, a, e.v);
          end
        end
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic direct(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    scl = 1'b1;      tick(Q);
    host_sda = 1'b0; tick(Q);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    scl = 1'b1;      tick(Q);
    host_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    host_sda = 1'b1; tick(Q);
    scl = 1'b1;      tick(Q);
    b = sda_line;    tick(Q);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(ack);
    exp_q.push_back('{v: {7'd0, exp_ack}, tag: tag});
    act_q.push_back({7'd0, ack});
  endtask

  task automatic recv_byte(input logic last, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(last);
    exp_q.push_back('{v: exp, tag: tag});
    act_q.push_back(b);
  endtask

  // write n bytes from wbuf starting at addr; shadow follows page wrap and protection
  task automatic wr_seq(input logic [7:0] addr, input int n, input string tag);
    logic [7:0] a;
    bus_start();
    send_byte(DEV_W, 1'b0, tag);
    send_byte(addr, 1'b0, tag);
    a = addr;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], 1'b0, tag);
      if (!(wp && a[7])) model[a] = wbuf[i];
      a = {a[7:3], a[2:0] + 3'd1};
    end
    bus_stop();
    bctr = a;
  endtask

  task automatic read_n(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      recv_byte((i == n - 1), model[bctr], tag);
      bctr = bctr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic rd_seq(input logic [7:0] addr, input int n, input string tag);
    bus_start();
    send_byte(DEV_W, 1'b0, tag);
    send_byte(addr, 1'b0, tag);
    bctr = addr;
    bus_start();
    send_byte(DEV_R, 1'b0, tag);
    read_n(n, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    bus_start();
    send_byte(DEV_R, 1'b0, tag);
    read_n(n, tag);
  endtask

  task automatic poll_ready(input logic exp_busy, input string tag);
    logic ack;
    bit ok;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(DEV_W[i]);
    recv_bit(ack);
    bus_stop();
    exp_q.push_back('{v: {7'd0, exp_busy}, tag: tag});
    act_q.push_back({7'd0, ack});
    ok = (ack == 1'b0);
    for (int k = 0; k < 20 && !ok; k++) begin
      bus_start();
      for (int i = 7; i >= 0; i--) send_bit(DEV_W[i]);
      recv_bit(ack);
      bus_stop();
      ok = (ack == 1'b0);
    end
    direct({7'd0, ok}, 8'h01, {tag, " ready after window"});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R11: released bus, zeroed array, counter at 0
    direct({7'd0, sda_oe}, 8'h00, "R11 sda released");
    cur_read(1, "R11 R7 counter at reset");

    // R3: wrong straps, no ack and ignored
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, 1'b1, "R3 strap mismatch");
    send_byte(8'h00, 1'b1, "R3 ignored after mismatch");
    bus_stop();

    // R4 byte write, R6 window, R7 counter after write, R8 random read
    wbuf[0] = 8'h5A;
    wr_seq(8'h10, 1, "R4 R2 byte write ack");
    poll_ready(1'b1, "R6 busy nack");
    cur_read(1, "R7 current after write");
    rd_seq(8'h10, 1, "R4 R8 random read");

    // short page mid-page, sequential read back
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_seq(8'h20, 3, "R5 page write ack");
    poll_ready(1'b1, "R6 busy nack page");
    rd_seq(8'h20, 3, "R9 sequential read");

    // page overrun wraps inside page
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    wr_seq(8'h3E, 4, "R5 wrap write ack");
    poll_ready(1'b1, "R6 busy nack wrap");
    rd_seq(8'h38, 8, "R5 page wrap contents");

    // counter after write at last slot of page wraps to page start
    wbuf[0] = 8'h47;
    wr_seq(8'h47, 1, "R7 write last slot");
    poll_ready(1'b1, "R6 busy nack slot");
    cur_read(2, "R7 counter wraps in page");

    // read wraps across top of array
    wbuf[0] = 8'h77;
    wr_seq(8'hFF, 1, "R9 top byte write");
    poll_ready(1'b1, "R6 busy nack top");
    wbuf[0] = 8'h19;
    wr_seq(8'h00, 1, "R9 bottom byte write");
    poll_ready(1'b1, "R6 busy nack bottom");
    rd_seq(8'hFE, 3, "R9 array wrap read");
    tick(4);
    direct({7'd0, sda_oe}, 8'h00, "R9 bus released after nack");
    cur_read(1, "R7 counter after read");

    // R1 R5: repeated START before STOP drops buffered data, no window
    bus_start();
    send_byte(DEV_W, 1'b0, "R1 abort select");
    send_byte(8'h50, 1'b0, "R1 abort addr");
    send_byte(8'h99, 1'b0, "R1 abort data");
    bus_start();
    bus_stop();
    poll_ready(1'b0, "R5 R6 no window after discard");
    rd_seq(8'h50, 1, "R5 discarded data not stored");

    // R10 write protect
    wp = 1'b1;
    wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
    wr_seq(8'h90, 2, "R10 protected bytes acked");
    poll_ready(1'b1, "R10 R6 window on protected write");
    wbuf[0] = 8'h34;
    wr_seq(8'h12, 1, "R10 lower half write");
    poll_ready(1'b1, "R10 R6 busy lower");
    rd_seq(8'h90, 2, "R10 upper half unchanged");
    rd_seq(8'h12, 1, "R10 lower half stored");
    wp = 1'b0;
    wbuf[0] = 8'hC3;
    wr_seq(8'h90, 1, "R10 unprotected write");
    poll_ready(1'b1, "R10 R6 busy unprotected");
    rd_seq(8'h90, 1, "R10 stored with wp low");

    tick(20);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard actual=%0d expected=0 items left", exp_q.size());
    end
    report();
    $finish;
  end
endmodule